// File: doc/BRIEF.md
# Expansion Priority Override Merge

This block sits on a memory expansion board mounted inside the machine. It lies between the processor's data strobe and the strobe input of the motherboard decoder. It decodes the top two address lines to find out whether an access falls in the window the internal expansion RAM serves. It merges that decision with an override request from the external expansion connector and drives one override level toward the motherboard decoder. A high override hides the access from the motherboard.

An external card that raises its override takes precedence. The override stays high, and the internal RAM select and transfer acknowledge are withheld for as long as the claim is present. The override output depends on address lines only. It is therefore settled before the data strobe falls.

A small owner state machine follows each bus cycle. Its states are OWN_IDLE (strobe released), OWN_SERVE (the internal RAM serves the cycle), OWN_YIELD (an external card has claimed the cycle) and OWN_BOARD (the motherboard serves it, for example the low quadrant or the I/O window). Each clock edge takes one of these transitions:

- go_idle: the strobe is high, so the next state is OWN_IDLE.
- go_yield: the strobe is low and the external claim is high, so the next state is OWN_YIELD.
- go_serve: the strobe is low, there is no external claim and the address is in the RAM window, so the next state is OWN_SERVE.
- go_board: the strobe is low and none of the above applies, so the next state is OWN_BOARD.

Top module: `xp_override_merge`

## Requirements
- R1: The RAM window is every address whose bit 19 XOR bit 18 is 1. For such an address `ovr_hi` is 1 whatever the strobe is.
- R2: While `ext_claim` is 1, `ovr_hi` is 1 for every address.
- R3: When bit 19 and bit 18 are both 1 (I/O window), or both 0, and `ext_claim` is 0, `ovr_hi` is 0. In these windows `ram_sel_n` never goes low.
- R4: `ram_sel_n` goes low only after a rising clock edge has sampled `ds_n` low, with the address in the RAM window and `ext_claim` low. Before that edge it stays high.
- R5: When `ext_claim` rises during a cycle the internal RAM serves, `ram_sel_n` returns high in the same cycle, without waiting for a clock edge.
- R6: `ack_drive` is 1 exactly when `ram_sel_n` is 0. Otherwise the acknowledge is released (0).
- R7: While `rst_n` is low and just after reset, `ram_sel_n` is 1 and `ack_drive` is 0.
- R8: When `ds_n` returns high, `ram_sel_n` is high at once and stays high after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 20 | Processor address lines |
| ds_n | input | 1 | Processor data strobe, active low |
| ext_claim | input | 1 | Override request from the external connector, active high |
| ovr_hi | output | 1 | Override to the motherboard decoder strobe input, high hides the access |
| ram_sel_n | output | 1 | Internal expansion RAM select, active low |
| ack_drive | output | 1 | 1 = pull transfer acknowledge low, 0 = released |

## Verification
The internal serve and the external claim can land in the same cycle. This happens when `ext_claim` rises while a RAM-window access is already in OWN_SERVE with the strobe held low. The bench provokes this by raising the claim at a falling edge in the middle of such an access. It then samples `ram_sel_n` and `ack_drive` before the next rising edge, expecting both to be released while `ovr_hi` stays high. A sweep over all four address quadrants, both claim levels and both strobe levels covers the ordinary combinations. In that sweep every expected level is computed from the address bits.

// File: rtl/xp_override_pkg.sv
package xp_override_pkg;
    typedef enum logic [1:0] {
        OWN_IDLE  = 2'd0,
        OWN_SERVE = 2'd1,
        OWN_YIELD = 2'd2,
        OWN_BOARD = 2'd3
    } owner_e;
endpackage

// File: rtl/xp_window_dec.sv
module xp_window_dec #(
    parameter int ADDR_W = 20
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              ram_win,
    output logic              io_win
);
    localparam int TOP = ADDR_W - 1;
    localparam int NXT = ADDR_W - 2;

    always_comb begin
        ram_win = addr[TOP] ^ addr[NXT];
        io_win  = addr[TOP] & addr[NXT];
    end
endmodule

// File: rtl/xp_owner_fsm.sv
module xp_owner_fsm
    import xp_override_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   ds_n,
    input  logic   ext_claim,
    input  logic   ram_win,
    output owner_e state
);
    owner_e next_state;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= OWN_IDLE;
        else        state <= next_state;
    end

    always_comb begin
        next_state = state;
        unique case (state)
            OWN_IDLE, OWN_SERVE, OWN_YIELD, OWN_BOARD: begin
                if (ds_n)           next_state = OWN_IDLE;   // go_idle
                else if (ext_claim) next_state = OWN_YIELD;  // go_yield
                else if (ram_win)   next_state = OWN_SERVE;  // go_serve
                else                next_state = OWN_BOARD;  // go_board
            end
            default: next_state = OWN_IDLE;
        endcase
    end
endmodule

// File: rtl/xp_override_merge.sv
module xp_override_merge
    import xp_override_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ds_n,
    input  logic              ext_claim,
    output logic              ovr_hi,
    output logic              ram_sel_n,
    output logic              ack_drive
);
    logic   ram_win;
    logic   io_win;
    owner_e state;
    logic   serving;

    xp_window_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr    (addr),
        .ram_win (ram_win),
        .io_win  (io_win)
    );

    xp_owner_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ds_n      (ds_n),
        .ext_claim (ext_claim),
        .ram_win   (ram_win),
        .state     (state)
    );

    // Output process: address-only override, strobe-qualified selects.
    always_comb begin
        ovr_hi  = ram_win | ext_claim;
        serving = 1'b0;
        unique case (state)
            OWN_SERVE: serving = ram_win & ~io_win & ~ext_claim & ~ds_n;
            OWN_IDLE, OWN_YIELD, OWN_BOARD: serving = 1'b0;
            default: serving = 1'b0;
        endcase
        ram_sel_n = ~serving;
        ack_drive = serving;
    end
endmodule

// File: rtl/xp_override_checker.sv
module xp_override_checker #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              ds_n,
    input logic              ext_claim,
    input logic              ovr_hi,
    input logic              ram_sel_n,
    input logic              ack_drive
);
    localparam int TOP = ADDR_W - 1;
    localparam int NXT = ADDR_W - 2;

    assert_ovr_ram_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (addr[TOP] != addr[NXT]) |-> ovr_hi);
    assert_ovr_ext_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ext_claim |-> ovr_hi);
    assert_io_no_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (addr[TOP] == addr[NXT]) |-> ram_sel_n);
    assert_sel_after_ds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_sel_n |-> $past(!ds_n));
    assert_sel_no_ext_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_sel_n |-> !ext_claim);
    assert_ack_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ack_drive == !ram_sel_n);
    assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ds_n |-> ram_sel_n);
endmodule

bind xp_override_merge xp_override_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (addr),
    .ds_n      (ds_n),
    .ext_claim (ext_claim),
    .ovr_hi    (ovr_hi),
    .ram_sel_n (ram_sel_n),
    .ack_drive (ack_drive)
);

// File: tb/test_xp_override_merge.sv
`timescale 1ns/1ps
module test_xp_override_merge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] addr = '0;
    logic        ds_n = 1'b1;
    logic        ext_claim = 1'b0;
    logic        ovr_hi, ram_sel_n, ack_drive;
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    xp_override_merge i_xp_override_merge (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ds_n(ds_n),
        .ext_claim(ext_claim), .ovr_hi(ovr_hi),
        .ram_sel_n(ram_sel_n), .ack_drive(ack_drive)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R7 reset state
        #5;
        chk("R7", "sel in reset", ram_sel_n, 1'b1);
        chk("R7", "ack in reset", ack_drive, 1'b0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #5;
        chk("R7", "sel after reset", ram_sel_n, 1'b1);
        chk("R7", "ack after reset", ack_drive, 1'b0);

        // Sweep: quadrants x offsets x claim x strobe
        for (int q = 0; q < 4; q++) begin
            for (int o = 0; o < 3; o++) begin
                for (int e = 0; e < 2; e++) begin
                    for (int d = 0; d < 2; d++) begin
                        logic [17:0] off;
                        logic win, exp_ovr, exp_sel;
                        off = (o == 0) ? 18'h00000 : (o == 1) ? 18'h1234A : 18'h3FFFF;
                        @(negedge clk);
                        ds_n = 1'b1; ext_claim = 1'b0;
                        @(negedge clk);
                        addr = {q[1:0], off};
                        ext_claim = e[0];
                        ds_n = d[0];
                        win = q[1] ^ q[0];
                        exp_ovr = win | e[0];
                        #1;
                        // R4: no select before a clock edge sees the strobe
                        chk("R4", "sel before edge", ram_sel_n, 1'b1);
                        @(posedge clk); #5;
                        exp_sel = win & ~e[0] & ~d[0];
                        if (e[0]) chk("R2", "ovr with claim", ovr_hi, 1'b1);
                        else if (win) chk("R1", "ovr in ram window", ovr_hi, 1'b1);
                        else chk("R3", "ovr outside ram window", ovr_hi, 1'b0);
                        if (!win) chk("R3", "sel outside window", ram_sel_n, 1'b1);
                        else chk("R4", "sel after edge", ram_sel_n, ~exp_sel);
                        chk("R6", "ack tracks sel", ack_drive, exp_sel);
                        chk("R1", "ovr level", ovr_hi, exp_ovr);
                    end
                end
            end
        end

        // R5: external claim arrives in the middle of a served cycle
        @(negedge clk);
        ds_n = 1'b1; ext_claim = 1'b0;
        @(negedge clk);
        addr = 20'h5_0000; ds_n = 1'b0;
        @(posedge clk); #5;
        chk("R4", "serving before claim", ram_sel_n, 1'b0);
        @(negedge clk);
        ext_claim = 1'b1;
        #1;
        chk("R5", "sel dropped same cycle", ram_sel_n, 1'b1);
        chk("R5", "ack dropped same cycle", ack_drive, 1'b0);
        chk("R5", "ovr kept high", ovr_hi, 1'b1);
        @(posedge clk); #5;
        chk("R5", "sel stays off", ram_sel_n, 1'b1);

        // R8: strobe release ends the serve
        @(negedge clk);
        ext_claim = 1'b0;
        @(posedge clk); #5;
        chk("R4", "serving again", ram_sel_n, 1'b0);
        @(negedge clk);
        ds_n = 1'b1;
        #1;
        chk("R8", "sel released at once", ram_sel_n, 1'b1);
        @(posedge clk); #5;
        chk("R8", "sel released after edge", ram_sel_n, 1'b1);
        chk("R8", "ack released after edge", ack_drive, 1'b0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule